// File: doc/BRIEF.md
# Sequential Instruction Prefetch Unit

This block fetches a straight-line instruction stream ahead of the decoder. Each request to memory asks for one aligned 32-bit word. An incrementer produces the next sequential word address, and a selector swaps in a redirect target when a taken branch or an exception entry arrives. Returned words go into a small word buffer. A halfword selector then hands the decoder one 16-bit halfword per handshake, lower half first.

A taken redirect empties the buffer. Any fetch already in flight is marked stale, and its data is thrown away when it returns. Fetch then restarts at the word that holds the target. If the target has address bit 1 set, the lower half of that first word is skipped. The memory side can stall a request by holding ready low, and it can answer one or more cycles after accepting. Only one fetch is in flight at a time. Buffer space is reserved when a request is issued, so a returning word always fits.

Top module: `ifetch_unit`

## Requirements
- R1: Every fetch request carries an address whose bits [1:0] are zero. Each request asks for one 32-bit word.
- R2: After a request is accepted with no taken redirect in the same cycle, the next request address is the accepted address plus 4.
- R3: A taken redirect sets the next request address to the target with bits [1:0] cleared, one cycle after the redirect is sampled. A redirect is taken when `redir_valid` is high and either `redir_cond` is 0 (unconditional) or `redir_pass` is 1.
- R4: A redirect with `redir_cond`=1 and `redir_pass`=0 has no effect. The request address and the halfword stream continue in sequence.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, and no redirect is taken, the request stays valid and its address does not change in the next cycle.
- R6: Fetch runs ahead only while stored words plus the one word in flight stay within DEPTH (4). With decode stalled, exactly DEPTH requests are accepted after a redirect, and `mem_req_valid` then stays low.
- R7: One cycle after a taken redirect, `dec_valid` is low. Data returned for a fetch that was in flight across the redirect never reaches decode.
- R8: Within each word, the lower halfword (bits [15:0]) is delivered before the upper halfword (bits [31:16]), so halfwords reach decode in address order.
- R9: When the redirect target has bit 1 set, the first halfword delivered is bits [31:16] of the first fetched word.
- R10: A halfword leaves only in a cycle where `dec_valid` and `dec_ready` are both high. Otherwise `dec_valid` and `dec_half` hold.
- R11: In and right after reset, `dec_valid` is low and the request address equals RESET_ADDR (0x100), with `mem_req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redir_valid | input | 1 | Redirect request this cycle |
| redir_cond | input | 1 | Redirect is conditional |
| redir_pass | input | 1 | Condition of a conditional redirect passed |
| redir_addr | input | ADDR_W | Redirect target (halfword aligned) |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_addr | output | ADDR_W | Word-aligned fetch address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Fetched word returns |
| mem_rsp_data | input | 32 | Fetched word |
| dec_valid | output | 1 | Halfword available to decode |
| dec_half | output | 16 | Instruction halfword |
| dec_ready | input | 1 | Decode takes the halfword |

## Verification
A redirect sampled at one edge shows its aligned target on `mem_req_addr`, and `dec_valid` low, in the very next cycle. An accepted request moves the address by 4 one cycle later. A returned word shows up on `dec_valid` in the cycle after its response edge. The bench drives inputs at the falling edge and samples half a nanosecond before the next rising edge. Every expectation is tied to the edge that produces it: address and flush checks are armed at the redirect edge and evaluated one sample later. The bench memory returns the word at address A as {A+2, A} in the low 16 address bits, so every delivered halfword must equal the running expected address. That single comparison covers ordering, skipping, flushing and stale-data loss under varied latency, stall and decode-ready patterns.

// File: rtl/ifu_pkg.sv
`timescale 1ns/1ps
// Shared widths and the buffer entry type of the prefetch unit.
// Assumes an instruction word is exactly two halfwords.
package ifu_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int HALF_BYTES = HALF_W / 8;
    localparam int HALF_BIT = $clog2(HALF_BYTES);

    // One buffered word plus a flag telling the selector to skip its low half.
    typedef struct packed {
        logic              skip_lo;
        logic [WORD_W-1:0] data;
    } pf_entry_t;
endpackage

// File: rtl/ifu_next_addr.sv
`timescale 1ns/1ps
// Next fetch address: the word incrementer and the redirect selector.
// Assumes targets are forced to word alignment here; a redirect beats advance.
module ifu_next_addr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              advance,
    input  logic              take,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(ifu_pkg::WORD_BYTES);
    localparam logic [ADDR_W-1:0] LOW_M = ADDR_W'(ifu_pkg::WORD_BYTES - 1);

    logic [ADDR_W-1:0] incr_addr;
    logic [ADDR_W-1:0] tgt_word;

    // Sequential successor of the current word.
    always_comb incr_addr = cur_addr + STEP;

    // Word holding the redirect target.
    always_comb tgt_word = target & ~LOW_M;

    // Select redirect, increment or hold.
    always_comb begin
        if (take)         next_addr = tgt_word;
        else if (advance) next_addr = incr_addr;
        else              next_addr = cur_addr;
    end
endmodule

// File: rtl/ifu_fetch_ctl.sv
`timescale 1ns/1ps
// Fetch request side: issues one word request at a time while the buffer
// has room, tracks the single in-flight fetch and drops it if a redirect
// made it stale. Assumes memory answers once per accepted request, at least
// one cycle after acceptance.
module ifu_fetch_ctl import ifu_pkg::*; #(
    parameter int                ADDR_W     = 32,
    parameter int                DEPTH      = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int               CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] target,
    input  logic [CNT_W-1:0]  buf_cnt,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              push_valid,
    output pf_entry_t         push_entry
);
    localparam logic [ADDR_W-1:0] LOW_M = ADDR_W'(WORD_BYTES - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;
    logic              busy_q;
    logic              stale_q;
    logic              skip_pend_q;
    logic              skip_fly_q;
    logic              accept;

    // Incrementer and redirect selector.
    ifu_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur_addr (addr_q),
        .advance  (accept),
        .take     (take),
        .target   (target),
        .next_addr(addr_d)
    );

    // Request only with no fetch in flight and a free buffer slot.
    always_comb mem_req_valid = !busy_q && (buf_cnt < CNT_W'(DEPTH));
    always_comb mem_req_addr  = addr_q;
    always_comb accept        = mem_req_valid && mem_req_ready;

    // A live response goes into the buffer unless a redirect happens now.
    always_comb push_valid = busy_q && mem_rsp_valid && !stale_q && !take;
    always_comb push_entry = '{skip_lo: skip_fly_q, data: mem_rsp_data};

    // Address, in-flight, stale and low-half skip tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= RESET_ADDR & ~LOW_M;
            busy_q      <= 1'b0;
            stale_q     <= 1'b0;
            skip_pend_q <= RESET_ADDR[HALF_BIT];
            skip_fly_q  <= 1'b0;
        end else begin
            addr_q <= addr_d;
            if (accept)             busy_q <= 1'b1;
            else if (mem_rsp_valid) busy_q <= 1'b0;
            if (take)        stale_q <= busy_q || accept;
            else if (accept) stale_q <= 1'b0;
            if (take)        skip_pend_q <= target[HALF_BIT];
            else if (accept) skip_pend_q <= 1'b0;
            if (accept)      skip_fly_q <= skip_pend_q;
        end
    end
endmodule

// File: rtl/ifu_word_fifo.sv
`timescale 1ns/1ps
// Circular buffer of fetched words. A flush empties it and beats a push
// or pop in the same cycle. Assumes the producer never pushes into a full
// buffer (space is reserved at request time).
module ifu_word_fifo import ifu_pkg::*; #(
    parameter int  DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  pf_entry_t        push_entry,
    input  logic             pop,
    output pf_entry_t        head,
    output logic             head_valid,
    output logic [CNT_W-1:0] count
);
    pf_entry_t        slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Pointer step with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualified buffer operations.
    always_comb do_push = push && !flush;
    always_comb do_pop  = pop && !flush && head_valid;

    // Oldest entry and its presence.
    always_comb head       = slot[rd_ptr];
    always_comb head_valid = (count != '0);

    // Entry storage.
    always_ff @(posedge clk) begin
        if (do_push) slot[wr_ptr] <= push_entry;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/ifu_half_sel.sv
`timescale 1ns/1ps
// Decode-side halfword selector: presents the low then the high half of
// the head word and pops the word after its high half is taken. Assumes
// the skip flag appears only on the first word after a flush.
module ifu_half_sel import ifu_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  pf_entry_t         head,
    input  logic              head_valid,
    input  logic              dec_ready,
    output logic              dec_valid,
    output logic [HALF_W-1:0] dec_half,
    output logic              pop
);
    logic hi_done_q;
    logic use_hi;
    logic fire;

    // Which half is on offer, and whether decode takes it.
    always_comb use_hi    = hi_done_q || head.skip_lo;
    always_comb dec_valid = head_valid;
    always_comb dec_half  = use_hi ? head.data[WORD_W-1:HALF_W] : head.data[HALF_W-1:0];
    always_comb fire      = head_valid && dec_ready;
    always_comb pop       = fire && use_hi;

    // Remember that the low half of the head word has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) hi_done_q <= 1'b0;
        else if (pop)        hi_done_q <= 1'b0;
        else if (fire)       hi_done_q <= 1'b1;
    end
endmodule

// File: rtl/ifetch_unit.sv
`timescale 1ns/1ps
// Top of the instruction prefetch unit: request control, word buffer and
// halfword selector. Assumes a redirect target is halfword aligned and the
// memory side returns one word per accepted request.
module ifetch_unit import ifu_pkg::*; #(
    parameter int                ADDR_W     = 32,
    parameter int                DEPTH      = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(32'h0000_0100)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_valid,
    input  logic              redir_cond,
    input  logic              redir_pass,
    input  logic [ADDR_W-1:0] redir_addr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              dec_valid,
    output logic [HALF_W-1:0] dec_half,
    input  logic              dec_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             take;
    logic             push_valid;
    pf_entry_t        push_entry;
    pf_entry_t        head;
    logic             head_valid;
    logic [CNT_W-1:0] buf_cnt;
    logic             pop;

    // A redirect counts when unconditional or its condition passed.
    always_comb take = redir_valid && (!redir_cond || redir_pass);

    ifu_fetch_ctl #(
        .ADDR_W    (ADDR_W),
        .DEPTH     (DEPTH),
        .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .target       (redir_addr),
        .buf_cnt      (buf_cnt),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .push_valid   (push_valid),
        .push_entry   (push_entry)
    );

    ifu_word_fifo #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (take),
        .push      (push_valid),
        .push_entry(push_entry),
        .pop       (pop),
        .head      (head),
        .head_valid(head_valid),
        .count     (buf_cnt)
    );

    ifu_half_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (take),
        .head      (head),
        .head_valid(head_valid),
        .dec_ready (dec_ready),
        .dec_valid (dec_valid),
        .dec_half  (dec_half),
        .pop       (pop)
    );
endmodule

// File: rtl/ifu_checker.sv
`timescale 1ns/1ps
// Protocol and ordering properties of the prefetch unit, bound to its top.
module ifu_checker #(
    parameter int  ADDR_W = 32,
    parameter int  DEPTH  = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_addr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              dec_valid,
    input logic              dec_ready,
    input logic [15:0]       dec_half,
    input logic [CNT_W-1:0]  buf_cnt
);
    p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    p_seq_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !take)
        |=> (mem_req_addr == $past(mem_req_addr) + ADDR_W'(4)));

    p_redirect_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (mem_req_addr == ($past(redir_addr) & ~ADDR_W'(3))));

    p_cond_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && !take && !(mem_req_valid && mem_req_ready))
        |=> $stable(mem_req_addr));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !take)
        |=> (mem_req_valid && $stable(mem_req_addr)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt <= CNT_W'(DEPTH));

    p_full_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_cnt == CNT_W'(DEPTH)) |-> !mem_req_valid);

    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !dec_valid);

    p_dec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready && !take) |=> (dec_valid && $stable(dec_half)));
endmodule

bind ifetch_unit ifu_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .redir_valid  (redir_valid),
    .redir_addr   (redir_addr),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .dec_valid    (dec_valid),
    .dec_ready    (dec_ready),
    .dec_half     (dec_half),
    .buf_cnt      (buf_cnt)
);

// File: tb/ifetch_unit_bench.sv
`timescale 1ns/1ps
module ifetch_unit_bench;
    localparam int          ADDR_W = 32;
    localparam int          DEPTH  = 4;
    localparam logic [31:0] RST_PC = 32'h0000_0100;

    typedef struct packed {
        logic [3:0]  lat;   // response latency in cycles
        logic [3:0]  rmod;  // ready low every rmod-th cycle (0/1: always ready)
        logic [3:0]  dmod;  // decode ready low every dmod-th cycle
        logic [1:0]  kind;  // 0 none, 1 unconditional, 2 cond pass, 3 cond fail
        logic [31:0] tgt;
        logic [7:0]  nh;    // halfwords to consume
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{lat:4'd1, rmod:4'd0, dmod:4'd0, kind:2'd0, tgt:32'h0,         nh:8'd12},
        '{lat:4'd3, rmod:4'd0, dmod:4'd0, kind:2'd1, tgt:32'h0000_1000, nh:8'd10},
        '{lat:4'd2, rmod:4'd3, dmod:4'd0, kind:2'd1, tgt:32'h0000_2006, nh:8'd10},
        '{lat:4'd1, rmod:4'd0, dmod:4'd2, kind:2'd3, tgt:32'h0000_5000, nh:8'd8},
        '{lat:4'd4, rmod:4'd2, dmod:4'd3, kind:2'd2, tgt:32'h0000_3002, nh:8'd12},
        '{lat:4'd1, rmod:4'd0, dmod:4'd0, kind:2'd1, tgt:32'h0000_4ffe, nh:8'd6},
        '{lat:4'd2, rmod:4'd0, dmod:4'd0, kind:2'd3, tgt:32'h0000_0008, nh:8'd6},
        '{lat:4'd1, rmod:4'd2, dmod:4'd0, kind:2'd2, tgt:32'h0000_7ff0, nh:8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redir_valid = 1'b0;
    logic        redir_cond = 1'b0;
    logic        redir_pass = 1'b0;
    logic [31:0] redir_addr = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        dec_valid;
    logic [15:0] dec_half;
    logic        dec_ready = 1'b0;

    always #2.5 clk = ~clk;

    ifetch_unit #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_ADDR(RST_PC)) u_ifetch_unit (
        .clk(clk), .rst_n(rst_n),
        .redir_valid(redir_valid), .redir_cond(redir_cond),
        .redir_pass(redir_pass), .redir_addr(redir_addr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .dec_valid(dec_valid),
        .dec_half(dec_half), .dec_ready(dec_ready)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // environment controls
    int          lat = 1, rmod = 0, dmod = 0;
    bit          mem_en = 1'b0, drdy_en = 1'b0, redir_req = 1'b0;
    logic [31:0] r_tgt = '0;
    bit          r_cond = 1'b0, r_pass = 1'b0;
    string       tag = "R8";

    // model state
    bit          pend = 1'b0;
    int          waitc = 0;
    logic [31:0] paddr = '0;
    logic [15:0] exp_h = RST_PC[15:0];
    int          got = 0;
    int          acc_cnt = 0;
    bit          since_redir = 1'b1;
    logic [31:0] last_acc = '0;
    bit          chk_after = 1'b0;
    logic [31:0] chk_tgt = '0;
    bit          hold_chk = 1'b0;
    logic [31:0] hold_addr = '0;
    bit          first_after = 1'b0;
    int          cyc = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Memory, decoder and redirect driver; drives at falling edge, samples before rising edge.
    initial begin
        forever begin
            @(negedge clk);
            mem_req_ready = mem_en && (rmod < 2 || (cyc % rmod) != 0);
            if (pend && waitc == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = {paddr[15:0] + 16'd2, paddr[15:0]};
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
                if (pend) waitc--;
            end
            dec_ready   = drdy_en && (dmod < 2 || (cyc % dmod) != 0);
            redir_valid = redir_req;
            redir_addr  = r_tgt;
            redir_cond  = r_cond;
            redir_pass  = r_pass;
            #2;
            if (rst_n) begin
                if (chk_after) begin
                    chk_after = 1'b0;
                    check(mem_req_addr == (chk_tgt & ~32'h3), "R3", mem_req_addr, chk_tgt & ~32'h3);
                    check(!dec_valid, "R7", {31'b0, dec_valid}, 32'h0);
                end
                if (hold_chk) begin
                    hold_chk = 1'b0;
                    check(mem_req_valid && mem_req_addr == hold_addr, "R5", mem_req_addr, hold_addr);
                end
                if (mem_rsp_valid) pend = 1'b0;
                if (mem_req_valid && mem_req_ready) begin
                    check(mem_req_addr[1:0] == 2'b00, "R1", mem_req_addr, mem_req_addr & ~32'h3);
                    if (!since_redir)
                        check(mem_req_addr == last_acc + 32'd4, "R2", mem_req_addr, last_acc + 32'd4);
                    since_redir = 1'b0;
                    last_acc = mem_req_addr;
                    pend  = 1'b1;
                    paddr = mem_req_addr;
                    waitc = lat - 1;
                    acc_cnt++;
                end else if (mem_req_valid && !redir_valid) begin
                    hold_chk  = 1'b1;
                    hold_addr = mem_req_addr;
                end
                if (dec_valid && dec_ready) begin
                    check(dec_half == exp_h, first_after ? "R9" : tag, {16'h0, dec_half}, {16'h0, exp_h});
                    first_after = 1'b0;
                    exp_h = exp_h + 16'd2;
                    got++;
                end
                if (redir_valid) begin
                    redir_req = 1'b0;
                    if (!redir_cond || redir_pass) begin
                        exp_h       = redir_addr[15:0];
                        since_redir = 1'b1;
                        chk_after   = 1'b1;
                        chk_tgt     = redir_addr;
                        acc_cnt     = 0;
                        first_after = redir_addr[1];
                    end
                end
            end
            cyc++;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R8: watchdog expired, halfwords actual %0d expected more", got);
            report();
            $finish;
        end
    end

    // Stimulus.
    initial begin
        int start;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: state right after reset
        check(!dec_valid, "R11", {31'b0, dec_valid}, 32'h0);
        check(mem_req_valid, "R11", {31'b0, mem_req_valid}, 32'h1);
        check(mem_req_addr == RST_PC, "R11", mem_req_addr, RST_PC);
        mem_en  = 1'b1;
        drdy_en = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            lat  = int'(VEC[i].lat);
            rmod = int'(VEC[i].rmod);
            dmod = int'(VEC[i].dmod);
            tag  = (VEC[i].kind == 2'd3) ? "R4" : "R8";
            if (VEC[i].kind != 2'd0) begin
                r_tgt  = VEC[i].tgt;
                r_cond = (VEC[i].kind >= 2'd2);
                r_pass = (VEC[i].kind == 2'd2);
                @(negedge clk);
                redir_req = 1'b1;
                wait (redir_req == 1'b0);
            end
            start = got;
            wait (got >= start + int'(VEC[i].nh));
        end

        // R6/R10: decode stalled, buffer fills to DEPTH and holds
        tag = "R8"; lat = 1; rmod = 0; dmod = 0;
        drdy_en = 1'b0;
        r_tgt = 32'h0000_6000; r_cond = 1'b0; r_pass = 1'b0;
        @(negedge clk);
        redir_req = 1'b1;
        wait (redir_req == 1'b0);
        repeat (30) @(negedge clk);
        #2;
        check(acc_cnt == DEPTH, "R6", acc_cnt, DEPTH);
        check(!mem_req_valid, "R6", {31'b0, mem_req_valid}, 32'h0);
        check(dec_valid && dec_half == 16'h6000, "R10", {16'h0, dec_half}, 32'h6000);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #2;
            check(dec_valid && dec_half == 16'h6000, "R10", {16'h0, dec_half}, 32'h6000);
        end
        drdy_en = 1'b1;
        start = got;
        wait (got >= start + 16);

        // R11: reset in the middle of a run
        drdy_en = 1'b0;
        mem_en  = 1'b0;
        wait (pend == 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        hold_chk = 1'b0;
        chk_after = 1'b0;
        repeat (2) @(negedge clk);
        #2;
        check(!dec_valid, "R11", {31'b0, dec_valid}, 32'h0);
        check(mem_req_addr == RST_PC, "R11", mem_req_addr, RST_PC);
        @(negedge clk);
        rst_n = 1'b1;
        exp_h = RST_PC[15:0];
        since_redir = 1'b1;
        first_after = 1'b0;
        mem_en  = 1'b1;
        drdy_en = 1'b1;
        start = got;
        wait (got >= start + 8);

        repeat (4) @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end
endmodule